// File: doc/BRIEF.md
# PCM Frame-Sync Serial Port

This block is a single-channel serial port for telephony voice samples. Each frame carries one 8-bit word in each direction. A frame-sync pulse marks the frame, and both the bit clock and the sync come from outside the block. The block runs on a faster system clock. On that clock it samples the bit clock, the sync and the serial receive line, and it turns their transitions into single-cycle edge events. All framing decisions are made from these events.

The port measures every sync pulse by counting how many falling bit-clock edges see the sync high. One edge means a short pulse and two or more mean a long pulse. The class of the most recent pulse selects the timing of the next frame, so the port follows a host that switches between the two conventions. The serial output has a separate enable for a shared bus. The release rule for that enable depends on the frame type. A power-down input stops the port, and after power-down or reset the output stays silent for two sync periods before the port may drive the bus again. The parallel transmit word is taken when a frame begins. The received word appears with a one-cycle strobe.

Top module: `pcm_frame_port`

## Requirements
- R1: While reset is held, and after its release until a frame runs, `ser_tx_en` and `rx_word_valid` are 0.
- R2: A sync pulse high on exactly one falling bit-clock edge is classed short, and a pulse high on two or more is classed long. The class of the most recent pulse sets the timing of the next frame.
- R3: Short timing: the first falling edge that sees sync high starts the frame. The MSB goes out on the next rising edge, and the later bits go out on the following rising edges.
- R4: Long timing: the rising edge of sync starts the frame. The MSB goes out on the first rising bit-clock edge at or after that point, and the later bits go out on the following rising edges.
- R5: Both directions are MSB first. Receive bits are captured on the eight falling edges that follow the MSB launch.
- R6: In a short-timed frame, `ser_tx_en` rises with the MSB launch. It falls at the falling edge in the middle of the LSB period.
- R7: In a long-timed frame, `ser_tx_en` is high from the sync rising edge for as long as sync is high or bits remain. It falls once sync is low and the falling edge inside the LSB has passed.
- R8: `tx_word` is latched at frame start. Changes made later in the frame do not alter the serial output.
- R9: The received word appears on `rx_word` with a single-cycle `rx_word_valid` pulse. The pulse comes right after the eighth capture edge, and there is exactly one pulse per running frame.
- R10: While `power_down` is high, `ser_tx_en` is 0 and no `rx_word_valid` pulse occurs.
- R11: After reset or after `power_down` falls, the frames started by the first two sync pulses keep `ser_tx_en` at 0. Receive still works in those frames.
- R12: Before any sync pulse has been classed, as right after reset, frames use short timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_down | input | 1 | Stops the port and silences the output while high |
| bit_clk | input | 1 | External serial bit clock |
| frame_sync | input | 1 | External frame-sync pulse, once per frame |
| ser_rx | input | 1 | Serial receive data |
| tx_word | input | WORD_BITS | Word to send, latched at frame start |
| ser_tx | output | 1 | Serial transmit data |
| ser_tx_en | output | 1 | Drive enable for the serial transmit line |
| rx_word | output | WORD_BITS | Last complete received word |
| rx_word_valid | output | 1 | One-cycle strobe marking a new `rx_word` |

## Verification
If the stored pulse class is wrong, the next frame runs one bit period early or late. Every transmitted bit then lands in the wrong half-period, and the received word comes back shifted, so the error shows in the first bit period of that frame. A wrong bit counter moves the enable release or the receive strobe. This shows around the LSB of the same frame. A wrong silence counter shows as the enable coming on in one of the two frames after power-down or reset, or staying off in the third.

// File: rtl/pcm_frame_pkg.sv
package pcm_frame_pkg;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_ARM  = 2'd1,
    FR_RUN  = 2'd2,
    FR_TAIL = 2'd3
  } frame_state_e;

  localparam int PIN_BCLK  = 0;
  localparam int PIN_FS    = 1;
  localparam int PIN_RX    = 2;
  localparam int PIN_COUNT = 3;

endpackage

// File: rtl/pcm_pin_sampler.sv
module pcm_pin_sampler #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] hist_q;

  // synchronizer chain plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      hist_q <= '0;
    end else begin
      stage_q[0] <= pins_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      hist_q <= stage_q[STAGES-1];
    end
  end

  assign level_o = stage_q[STAGES-1];

  for (genvar b = 0; b < WIDTH; b++) begin : g_edge
    assign rise_o[b] = level_o[b] & ~hist_q[b];
    assign fall_o[b] = ~level_o[b] & hist_q[b];
  end

endmodule

// File: rtl/pcm_sync_classifier.sv
module pcm_sync_classifier #(
  parameter int LONG_EDGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_level,
  input  logic fs_rise,
  input  logic fs_fall,
  input  logic bclk_fall,
  output logic prev_long_o,
  output logic first_fall_o
);

  localparam int CNT_W = $clog2(LONG_EDGES + 1);
  localparam logic [CNT_W-1:0] LONG_LIMIT = CNT_W'(LONG_EDGES);

  logic [CNT_W-1:0] edges_q, edges_d;
  logic             long_q, long_d;

  // count falling bit-clock edges seen while sync is high, saturating
  always_comb begin
    edges_d = edges_q;
    if (fs_rise) begin
      edges_d = (bclk_fall && fs_level) ? CNT_W'(1) : '0;
    end else if (fs_level && bclk_fall && (edges_q < LONG_LIMIT)) begin
      edges_d = edges_q + 1'b1;
    end
  end

  // class is committed when the pulse ends
  always_comb begin
    long_d = long_q;
    if (fs_fall) long_d = (edges_q >= LONG_LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges_q <= '0;
      long_q  <= 1'b0;
    end else begin
      edges_q <= edges_d;
      long_q  <= long_d;
    end
  end

  assign prev_long_o  = long_q;
  assign first_fall_o = bclk_fall & fs_level & (fs_rise | (edges_q == '0));

endmodule

// File: rtl/pcm_frame_ctrl.sv
module pcm_frame_ctrl
  import pcm_frame_pkg::*;
#(
  parameter int WORD_BITS   = 8,
  parameter int MUTE_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic power_down,
  input  logic bclk_rise,
  input  logic bclk_fall,
  input  logic fs_level,
  input  logic fs_rise,
  input  logic first_fall,
  input  logic prev_long,
  output logic load_o,
  output logic shift_o,
  output logic capture_o,
  output logic word_done_o,
  output logic drive_o
);

  localparam int CNT_W  = $clog2(WORD_BITS + 1);
  localparam int HOLD_W = $clog2(MUTE_FRAMES + 1);
  localparam logic [CNT_W-1:0]  ALL_BITS  = CNT_W'(WORD_BITS);
  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(WORD_BITS - 1);
  localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(MUTE_FRAMES);

  frame_state_e      state_q, state_d;
  logic              long_q, long_d;
  logic [CNT_W-1:0]  sent_q, sent_d;
  logic [CNT_W-1:0]  got_q, got_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              mute_q, mute_d;
  logic              drive_q, drive_d;
  logic              start_long, start_short, start;

  assign start_long  = prev_long & fs_rise;
  assign start_short = ~prev_long & first_fall;
  assign start       = ~power_down & (start_long | start_short);

  // silence window: counts sync pulses after reset or power-down
  always_comb begin
    hold_d = hold_q;
    mute_d = mute_q;
    if (power_down) begin
      hold_d = HOLD_INIT;
      mute_d = 1'b1;
    end else if (fs_rise) begin
      mute_d = (hold_q != '0);
      if (hold_q != '0) hold_d = hold_q - 1'b1;
    end
  end

  // frame sequencing
  always_comb begin
    state_d     = state_q;
    long_d      = long_q;
    sent_d      = sent_q;
    got_d       = got_q;
    load_o      = 1'b0;
    shift_o     = 1'b0;
    capture_o   = 1'b0;
    word_done_o = 1'b0;
    if (power_down) begin
      state_d = FR_IDLE;
    end else if (start) begin
      load_o = 1'b1;
      long_d = start_long;
      got_d  = '0;
      if (start_long && bclk_rise) begin
        state_d = FR_RUN;
        sent_d  = CNT_W'(1);
      end else begin
        state_d = FR_ARM;
        sent_d  = '0;
      end
    end else begin
      case (state_q)
        FR_ARM: begin
          if (bclk_rise) begin
            state_d = FR_RUN;
            sent_d  = CNT_W'(1);
          end
        end
        FR_RUN: begin
          if (bclk_rise && (sent_q < ALL_BITS)) begin
            shift_o = 1'b1;
            sent_d  = sent_q + 1'b1;
          end
          if (bclk_fall) begin
            capture_o = 1'b1;
            got_d     = got_q + 1'b1;
            if (got_q == LAST_BIT) begin
              word_done_o = 1'b1;
              state_d     = (long_q && fs_level) ? FR_TAIL : FR_IDLE;
            end
          end
        end
        FR_TAIL: begin
          if (!fs_level) state_d = FR_IDLE;
        end
        default: state_d = FR_IDLE;
      endcase
    end
  end

  // output enable follows the next state so it switches with the data
  always_comb begin
    drive_d = 1'b0;
    if (!power_down && !mute_d) begin
      case (state_d)
        FR_ARM:  drive_d = long_d & fs_level;
        FR_RUN:  drive_d = 1'b1;
        FR_TAIL: drive_d = fs_level;
        default: drive_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      long_q  <= 1'b0;
      sent_q  <= '0;
      got_q   <= '0;
      hold_q  <= HOLD_INIT;
      mute_q  <= 1'b1;
      drive_q <= 1'b0;
    end else begin
      state_q <= state_d;
      long_q  <= long_d;
      sent_q  <= sent_d;
      got_q   <= got_d;
      hold_q  <= hold_d;
      mute_q  <= mute_d;
      drive_q <= drive_d;
    end
  end

  assign drive_o = drive_q;

endmodule

// File: rtl/pcm_word_shifter.sv
module pcm_word_shifter #(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 shift_i,
  input  logic                 capture_i,
  input  logic                 done_i,
  input  logic                 rx_bit_i,
  input  logic [WORD_BITS-1:0] tx_word_i,
  output logic                 tx_bit_o,
  output logic [WORD_BITS-1:0] rx_word_o,
  output logic                 rx_valid_o
);

  logic [WORD_BITS-1:0] tx_q, tx_d;
  logic [WORD_BITS-1:0] rx_sh_q, rx_sh_d;
  logic [WORD_BITS-1:0] word_q, word_d;
  logic                 valid_q, valid_d;

  always_comb begin
    tx_d = tx_q;
    if (load_i)       tx_d = tx_word_i;
    else if (shift_i) tx_d = {tx_q[WORD_BITS-2:0], 1'b0};
  end

  always_comb begin
    rx_sh_d = rx_sh_q;
    if (capture_i) rx_sh_d = {rx_sh_q[WORD_BITS-2:0], rx_bit_i};
    word_d  = done_i ? rx_sh_d : word_q;
    valid_d = done_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_sh_q <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      tx_q    <= tx_d;
      rx_sh_q <= rx_sh_d;
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign tx_bit_o   = tx_q[WORD_BITS-1];
  assign rx_word_o  = word_q;
  assign rx_valid_o = valid_q;

endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port
  import pcm_frame_pkg::*;
#(
  parameter int WORD_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LONG_EDGES  = 2,
  parameter int MUTE_FRAMES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 power_down,
  input  logic                 bit_clk,
  input  logic                 frame_sync,
  input  logic                 ser_rx,
  input  logic [WORD_BITS-1:0] tx_word,
  output logic                 ser_tx,
  output logic                 ser_tx_en,
  output logic [WORD_BITS-1:0] rx_word,
  output logic                 rx_word_valid
);

  logic [PIN_COUNT-1:0] pins, lvl, rise, fall;
  logic bclk_rise, bclk_fall, fs_level, fs_rise, fs_fall, rx_level;
  logic prev_long, first_fall;
  logic load, shift, capture, word_done;
  logic unused_pins;

  assign pins[PIN_BCLK] = bit_clk;
  assign pins[PIN_FS]   = frame_sync;
  assign pins[PIN_RX]   = ser_rx;

  pcm_pin_sampler #(
    .WIDTH  (PIN_COUNT),
    .STAGES (SYNC_STAGES)
  ) i_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins_i  (pins),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  assign bclk_rise = rise[PIN_BCLK];
  assign bclk_fall = fall[PIN_BCLK];
  assign fs_level  = lvl[PIN_FS];
  assign fs_rise   = rise[PIN_FS];
  assign fs_fall   = fall[PIN_FS];
  assign rx_level  = lvl[PIN_RX];
  assign unused_pins = ^{lvl[PIN_BCLK], rise[PIN_RX], fall[PIN_RX]};

  pcm_sync_classifier #(
    .LONG_EDGES (LONG_EDGES)
  ) i_classifier (
    .clk          (clk),
    .rst_n        (rst_n),
    .fs_level     (fs_level),
    .fs_rise      (fs_rise),
    .fs_fall      (fs_fall),
    .bclk_fall    (bclk_fall),
    .prev_long_o  (prev_long),
    .first_fall_o (first_fall)
  );

  pcm_frame_ctrl #(
    .WORD_BITS   (WORD_BITS),
    .MUTE_FRAMES (MUTE_FRAMES)
  ) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .power_down  (power_down),
    .bclk_rise   (bclk_rise),
    .bclk_fall   (bclk_fall),
    .fs_level    (fs_level),
    .fs_rise     (fs_rise),
    .first_fall  (first_fall),
    .prev_long   (prev_long),
    .load_o      (load),
    .shift_o     (shift),
    .capture_o   (capture),
    .word_done_o (word_done),
    .drive_o     (ser_tx_en)
  );

  pcm_word_shifter #(
    .WORD_BITS (WORD_BITS)
  ) i_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .shift_i    (shift),
    .capture_i  (capture),
    .done_i     (word_done),
    .rx_bit_i   (rx_level),
    .tx_word_i  (tx_word),
    .tx_bit_o   (ser_tx),
    .rx_word_o  (rx_word),
    .rx_valid_o (rx_word_valid)
  );

endmodule

// File: rtl/pcm_frame_port_chk.sv
module pcm_frame_port_chk #(
  parameter int MUTE_FRAMES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic power_down,
  input logic ser_tx_en,
  input logic rx_word_valid,
  input logic bclk_fall,
  input logic fs_rise
);

  localparam int RW = $clog2(MUTE_FRAMES + 2);
  localparam logic [RW-1:0] QUIET_LAST = RW'(MUTE_FRAMES);

  logic [RW-1:0] rises_q;

  // sync pulses seen since reset or power-down, saturating one past the window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rises_q <= '0;
    else if (power_down) rises_q <= '0;
    else if (fs_rise && (rises_q <= QUIET_LAST)) rises_q <= rises_q + 1'b1;
  end

  assert_no_drive_pd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |=> !ser_tx_en);

  assert_no_valid_pd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |=> !rx_word_valid);

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_valid |=> !rx_word_valid);

  assert_valid_after_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_valid |-> $past(bclk_fall));

  assert_quiet_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rises_q <= QUIET_LAST) |-> !ser_tx_en);

endmodule

bind pcm_frame_port pcm_frame_port_chk #(
  .MUTE_FRAMES (MUTE_FRAMES)
) i_pcm_frame_port_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .power_down    (power_down),
  .ser_tx_en     (ser_tx_en),
  .rx_word_valid (rx_word_valid),
  .bclk_fall     (bclk_fall),
  .fs_rise       (fs_rise)
);

// File: tb/test_pcm_frame_port.sv
module test_pcm_frame_port;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME_BITS = 16;
  localparam int NUM_FRAMES = 64;

  logic       clk;
  logic       rst_n;
  logic       power_down;
  logic       bit_clk;
  logic       frame_sync;
  logic       ser_rx;
  logic [7:0] tx_word;
  logic       ser_tx;
  logic       ser_tx_en;
  logic [7:0] rx_word;
  logic       rx_word_valid;

  int checks;
  int fails;
  int valid_cnt;
  logic [7:0] got_rx;
  bit done;

  pcm_frame_port i_pcm_frame_port (
    .clk           (clk),
    .rst_n         (rst_n),
    .power_down    (power_down),
    .bit_clk       (bit_clk),
    .frame_sync    (frame_sync),
    .ser_rx        (ser_rx),
    .tx_word       (tx_word),
    .ser_tx        (ser_tx),
    .ser_tx_en     (ser_tx_en),
    .rx_word       (rx_word),
    .rx_word_valid (rx_word_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rx_word_valid) begin
      valid_cnt++;
      got_rx = rx_word;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pulse_width(input int i);
    case (i % 7)
      0: return 3;
      1: return 1;
      2: return 2;
      3: return 1;
      4: return 10;
      5: return 1;
      default: return 5;
    endcase
  endfunction

  // one frame: 16 bit periods, bit clock rises at period start, falls mid-period
  task automatic run_frame(input int width, input logic [7:0] txb, input logic [7:0] rxb,
                           input bit prev_long, input bit muted, input bit pd_on, input int idx);
    int d;
    d = prev_long ? 0 : 1;
    valid_cnt = 0;
    tx_word = txb;
    for (int p = 0; p < FRAME_BITS; p++) begin
      for (int h = 0; h < 2; h++) begin
        int hidx;
        int b;
        bit exp_oe;
        string lab;
        @(negedge clk);
        power_down = pd_on;
        bit_clk    = (h == 0);
        frame_sync = (p < width);
        b = p - d;
        if (h == 0) ser_rx = (b >= 0 && b < 8) ? rxb[7-b] : 1'b0;
        if (p == 2 && h == 0) tx_word = ~txb;
        repeat (6) @(negedge clk);
        hidx = 2*p + h;
        if (pd_on || muted) exp_oe = 1'b0;
        else if (!prev_long) exp_oe = (hidx >= 2) && (hidx <= 16);
        else exp_oe = (p < width) || (hidx <= 14);
        if (pd_on) lab = "R10 enable in power-down";
        else if (muted) lab = "R11 enable in quiet frame";
        else if (!prev_long) lab = "R6 enable short frame";
        else lab = "R7 enable long frame";
        check($sformatf("%s f%0d h%0d", lab, idx, hidx), int'(ser_tx_en), int'(exp_oe));
        if (exp_oe && b >= 0 && b < 8) begin
          if (b == 0) lab = "R2 first bit after class";
          else if (p >= 2) lab = "R8 latched word bit";
          else if (!prev_long) lab = "R3 short bit";
          else lab = "R4 long bit";
          check($sformatf("%s f%0d b%0d", lab, idx, b), int'(ser_tx), int'(txb[7-b]));
        end
        @(negedge clk);
      end
    end
    check($sformatf("R9 strobe count f%0d", idx), valid_cnt, pd_on ? 0 : 1);
    if (!pd_on) begin
      if (idx == 0) check("R12 first frame after reset rx word", int'(got_rx), int'(rxb));
      else check($sformatf("R5 rx word f%0d", idx), int'(got_rx), int'(rxb));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit prev_long;
    int hold;
    checks     = 0;
    fails      = 0;
    done       = 1'b0;
    rst_n      = 1'b0;
    power_down = 1'b0;
    bit_clk    = 1'b0;
    frame_sync = 1'b0;
    ser_rx     = 1'b0;
    tx_word    = 8'h00;
    repeat (5) @(negedge clk);
    check("R1 enable in reset", int'(ser_tx_en), 0);
    check("R1 strobe in reset", int'(rx_word_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 enable after reset", int'(ser_tx_en), 0);
    check("R1 strobe after reset", int'(rx_word_valid), 0);

    prev_long = 1'b0;
    hold      = 2;
    for (int i = 0; i < NUM_FRAMES; i++) begin
      int w;
      bit pd_on;
      bit muted;
      logic [7:0] txb;
      logic [7:0] rxb;
      w     = pulse_width(i);
      pd_on = (i == 20) || (i == 21) || (i == 45);
      txb   = 8'((i * 29 + 7) ^ (i << 4));
      rxb   = 8'(i * 53 + 11);
      muted = 1'b0;
      if (!pd_on) begin
        muted = (hold > 0);
        if (hold > 0) hold--;
      end
      run_frame(w, txb, rxb, prev_long, muted, pd_on, i);
      if (pd_on) hold = 2;
      prev_long = (w >= 2);
    end

    power_down = 1'b0;
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule